// File: doc/BRIEF.md
# Charger Presence Edge Interrupt Register

This block is a single 8-bit control and status register with the edge-sensing logic that turns changes on a charger-presence input into an interrupt. The raw presence level is synchronized into the core clock. A programmable sense field chooses which transitions count: connection only, disconnection only, both, or none. A matching transition sets a sticky flag. The flag raises the interrupt request when the local enable bit and the global interrupt enable are both set.

Software reads and writes the register through a plain address/write-strobe port with a combinational read path. The flag is cleared either by the interrupt acknowledge or by writing one to the flag bit. A charge-switch-off input overrides the sense logic. While it is high, detection is on regardless of the sense field, and the charger is seen as connected. A read-only status bit reports the battery-pin comparator result, but only while detection is active.

Top module: `chrg_sense_csr`

## Requirements
- R1: After reset every register bit reads zero and `irq_req` is low.
- R2: The register answers only at address `REG_ADDR`, and any other address reads 0x00. The bit fields are: bits 7:5 always read zero; bit 4 is the read-only battery status; bits 3:2 are the sense field; bit 1 is the flag; bit 0 is the enable. Writes to bits 7:4 have no effect.
- R3: The sense field selects which presence edges set the flag: 2'b00 rising (connect), 2'b01 falling (disconnect), 2'b10 either edge, 2'b11 none.
- R4: Presence passes through a two-stage synchronizer plus an edge register. A level change applied before a rising clock edge is visible in the flag after the third rising edge, and not after the second.
- R5: The flag clears on `irq_ack` or on a register write with bit 1 set. A write with bit 1 clear leaves the flag unchanged.
- R6: When a set event and a clear fall in the same cycle, the flag ends at one.
- R7: `irq_req` is high exactly when the flag, the enable bit and `gie` are all one.
- R8: Bit 4 reads `batt_hi` while detection is active and zero otherwise. Detection is active when the sense field is not 2'b11 or when `sw_off` is high.
- R9: While `sw_off` is high, presence is treated as one. With the sense field at 2'b11, the forced detection senses connection (rising edges), so raising `sw_off` with the charger absent sets the flag.
- R10: The previous-sample register follows presence in every mode. An edge that happened while sensing was off is not reported after sensing is turned back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | ADDR_W | Register address |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Combinational read data |
| pres_raw | input | 1 | Asynchronous charger-presence level |
| batt_hi | input | 1 | Battery pin above threshold (synchronous) |
| sw_off | input | 1 | Charge switch disabled (synchronous) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt taken, clears flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a set event that lands in the very cycle of a write-one-to-clear. The synchronizer delay makes edges from `pres_raw` hard to line up with a bus write. The bench instead raises `sw_off` on the same clock edge as the clearing write, because forced presence takes effect without passing through the synchronizer. The bench also reaches a sensing-off-then-on sequence by moving presence while the sense field is 2'b11, and only then selecting rising-edge detection.

// File: rtl/chrg_sense_pkg.sv
package chrg_sense_pkg;

   typedef enum logic [1:0] {
      SNS_CONNECT    = 2'b00,
      SNS_DISCONNECT = 2'b01,
      SNS_EITHER     = 2'b10,
      SNS_OFF        = 2'b11
   } sense_e;

   localparam int BIT_IE     = 0;
   localparam int BIT_FLAG   = 1;
   localparam int BIT_SNS_LO = 2;
   localparam int BIT_SNS_HI = 3;
   localparam int BIT_BATT   = 4;
   localparam int USED_BITS  = 5;

endpackage

// File: rtl/chrg_sync.sv
module chrg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("chrg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/chrg_edge_sel.sv
module chrg_edge_sel
   import chrg_sense_pkg::*;
#(
   parameter sense_e FORCED_SENSE = SNS_CONNECT
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pres_sync,
   input  logic   force_on,
   input  sense_e sense,
   output logic   evt,
   output logic   det_en
);
   if (FORCED_SENSE == SNS_OFF) begin : g_bad_forced
      $error("chrg_edge_sel: forced sense cannot be the off code");
   end

   logic   eff_pres, prev_q, rise, fall;
   sense_e act_sense;

   assign eff_pres = force_on | pres_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= eff_pres;
   end

   assign rise      = eff_pres & ~prev_q;
   assign fall      = ~eff_pres & prev_q;
   assign act_sense = (sense == SNS_OFF && force_on) ? FORCED_SENSE : sense;
   assign det_en    = (sense != SNS_OFF) | force_on;

   always_comb begin
      unique case (act_sense)
         SNS_CONNECT:    evt = rise;
         SNS_DISCONNECT: evt = fall;
         SNS_EITHER:     evt = rise | fall;
         default:        evt = 1'b0;
      endcase
   end

   // R3: the off code with no forcing never produces an event
   a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == SNS_OFF && !force_on) |-> !evt);
endmodule

// File: rtl/chrg_flag_ctl.sv
module chrg_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic w1c,
   input  logic ack,
   input  logic ie,
   input  logic gie,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q <= 1'b0;
      else if (set_evt)      flag_q <= 1'b1;
      else if (w1c || ack)   flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q & ie & gie;

   // R6: a set event always leaves the flag high
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q);
   // R5: acknowledge without a concurrent event clears the flag
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !set_evt) |=> !flag_q);
   // R5: without event or clear request the flag holds
   a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt && !w1c && !ack) |=> $stable(flag_q));
   // R3: the flag only rises after an edge event
   a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(set_evt));
endmodule

// File: rtl/chrg_sense_csr.sv
module chrg_sense_csr
   import chrg_sense_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 8,
   parameter int unsigned REG_ADDR    = 32'h34,
   parameter int          SYNC_STAGES = 2,
   parameter sense_e      FORCED_SNS  = SNS_CONNECT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_wr,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   input  logic              pres_raw,
   input  logic              batt_hi,
   input  logic              sw_off,
   input  logic              gie,
   input  logic              irq_ack,
   output logic              irq_req
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   if (DATA_W < USED_BITS) begin : g_bad_width
      $error("chrg_sense_csr: DATA_W too small for the field layout");
   end
   if (ADDR_W < 32 && REG_ADDR >= (32'd1 << ADDR_W)) begin : g_bad_addr
      $error("chrg_sense_csr: REG_ADDR does not fit in ADDR_W");
   end

   logic   hit, wr_hit, w1c;
   logic   pres_sync, evt, det_en, flag;
   logic   ie_q;
   sense_e sense_q;

   assign hit    = (csr_addr == HIT_ADDR);
   assign wr_hit = hit & csr_wr;
   assign w1c    = wr_hit & csr_wdata[BIT_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= SNS_CONNECT;
         ie_q    <= 1'b0;
      end else if (wr_hit) begin
         sense_q <= sense_e'(csr_wdata[BIT_SNS_HI:BIT_SNS_LO]);
         ie_q    <= csr_wdata[BIT_IE];
      end
   end

   chrg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pres_raw),
      .q_sync  (pres_sync)
   );

   chrg_edge_sel #(.FORCED_SENSE(FORCED_SNS)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pres_sync (pres_sync),
      .force_on  (sw_off),
      .sense     (sense_q),
      .evt       (evt),
      .det_en    (det_en)
   );

   chrg_flag_ctl u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (evt),
      .w1c     (w1c),
      .ack     (irq_ack),
      .ie      (ie_q),
      .gie     (gie),
      .flag    (flag),
      .irq     (irq_req)
   );

   always_comb begin
      csr_rdata = '0;
      if (hit) begin
         csr_rdata[BIT_BATT]              = batt_hi & det_en;
         csr_rdata[BIT_SNS_HI:BIT_SNS_LO] = sense_q;
         csr_rdata[BIT_FLAG]              = flag;
         csr_rdata[BIT_IE]                = ie_q;
      end
   end

   // R7: no request while interrupts are globally masked
   a_r7_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq_req);
   // R7: no request while the enable bit is clear
   a_r7_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !csr_rdata[BIT_IE]) |-> !irq_req);
   // R2: reserved bits never read as one
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[DATA_W-1:USED_BITS] == '0);
endmodule

// File: tb/sim_chrg_sense_csr.sv
`timescale 1ns/1ps
module sim_chrg_sense_csr;
   localparam logic [7:0] REG = 8'h34;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = REG, wdata = '0, rdata;
   logic       wr_en = 0, pres = 0, batt = 0, swoff = 0, gie = 0, ack = 0, irq;
   int         checks = 0, errors = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   chrg_sense_csr u0 (
      .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_wr(wr_en),
      .csr_wdata(wdata), .csr_rdata(rdata), .pres_raw(pres),
      .batt_hi(batt), .sw_off(swoff), .gie(gie), .irq_ack(ack), .irq_req(irq)
   );

   // {sense[1:0], start level, end level, expected flag}
   localparam logic [4:0] VEC [8] = '{
      {2'b00, 1'b0, 1'b1, 1'b1}, {2'b00, 1'b1, 1'b0, 1'b0},
      {2'b01, 1'b0, 1'b1, 1'b0}, {2'b01, 1'b1, 1'b0, 1'b1},
      {2'b10, 1'b0, 1'b1, 1'b1}, {2'b10, 1'b1, 1'b0, 1'b1},
      {2'b11, 1'b0, 1'b1, 1'b0}, {2'b11, 1'b1, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      addr = REG; wdata = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(output logic [7:0] d);
      addr = REG; #1; d = rdata;
   endtask

   initial begin
      logic [7:0] d;
      tick(3);
      rd(d); chk("R1 reset value", d, 8'h00);
      chk("R1 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1; tick(2);

      // R2 layout and decoding
      wr(8'hFF); rd(d); chk("R2 write all ones", d, 8'h0D);
      addr = REG + 8'd1; #1; chk("R2 other address", rdata, 8'h00);
      batt = 1; rd(d); chk("R8 status off when sensing off", d, 8'h0D);
      wr(8'h01); rd(d); chk("R8 status follows comparator", d, 8'h11);
      batt = 0;

      // R3 edge selection table
      for (int i = 0; i < 8; i++) begin
         pres = VEC[i][2]; tick(5);
         wr({4'b0000, VEC[i][4:3], 2'b10});
         tick(1); pres = VEC[i][1]; tick(5);
         rd(d); chk($sformatf("R3 vector %0d", i), {7'd0, d[1]}, {7'd0, VEC[i][0]});
      end

      // R4 latency
      pres = 0; tick(5); wr(8'h02); tick(1);
      pres = 1; tick(2); rd(d); chk("R4 flag not yet after two edges", {7'd0, d[1]}, 8'h00);
      tick(1); rd(d); chk("R4 flag after third edge", {7'd0, d[1]}, 8'h01);

      // R5 write zero keeps flag, R7 gating
      wr(8'h00); rd(d); chk("R5 write zero keeps flag", {7'd0, d[1]}, 8'h01);
      wr(8'h01); #1; chk("R7 masked by gie", {7'd0, irq}, 8'h00);
      gie = 1; #1; chk("R7 request raised", {7'd0, irq}, 8'h01);
      @(negedge clk); ack = 1; @(negedge clk); ack = 0;
      rd(d); chk("R5 ack clears flag", {7'd0, d[1]}, 8'h00);
      chk("R7 request drops", {7'd0, irq}, 8'h00);
      gie = 0;
      pres = 0; tick(5); pres = 1; tick(5);
      wr(8'h02); rd(d); chk("R5 write one clears flag", {7'd0, d[1]}, 8'h00);

      // R6 set wins over write-one-to-clear in the same cycle
      pres = 0; tick(5); wr(8'h02);
      @(negedge clk); swoff = 1; addr = REG; wdata = 8'h02; wr_en = 1;
      @(negedge clk); wr_en = 0;
      rd(d); chk("R6 set beats clear", {7'd0, d[1]}, 8'h01);
      wr(8'h02); rd(d); chk("R9 held switch-off gives no repeat", {7'd0, d[1]}, 8'h00);

      // R9 forced detection with sense off
      swoff = 0; tick(2); wr(8'h0E); tick(2);
      batt = 1; swoff = 1; tick(1);
      rd(d); chk("R9 forced connect and status", d, 8'h1E);
      swoff = 0; tick(1);
      rd(d); chk("R8 status drops without force", d, 8'h0E);
      batt = 0;

      // R10 edge during sensing-off not reported later
      wr(8'h0E); pres = 1; tick(5);
      wr(8'h02); tick(3);
      rd(d); chk("R10 stale edge ignored", {7'd0, d[1]}, 8'h00);
      pres = 0; tick(5); pres = 1; tick(5);
      rd(d); chk("R10 new edge reported", {7'd0, d[1]}, 8'h01);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule